// File: doc/BRIEF.md
# Processor Reset Exception Sequencer

This block watches two active-low reset requests: a general reset line and a separate cold-reset line. It classifies each reset event as cold or soft (warm). Both lines are first brought into the core clock domain. The block then tracks each event from its start to its release.

When a reset begins, the block sends a one-cycle flush pulse that clears the processor's state machines. In that same cycle it captures the program counter that was interrupted. When compressed-ISA execution is enabled, it also captures the current ISA mode.

When the reset is released, the block issues one vector-fetch pulse carrying the reset vector address. In that same cycle it writes the reset-related status bits. For a soft reset only, it also writes the saved PC into the error exception PC. A cold-reset assertion at any moment of an event makes the whole event cold.

Top module: `rst_exc_seq`

## Requirements
- R1: Each reset event produces exactly one `flush_o` pulse, one cycle wide. The pulse is high in the third clock edge after the first reset input goes low. It marks the start of the event, and a cold request added to an event already in progress gives no second pulse.
- R2: Each release produces exactly one `vec_fetch_o` pulse, one cycle wide. The pulse is high at the third clock edge after the last active reset input returns high.
- R3: In the `vec_fetch_o` cycle, `vec_addr_o` holds the reset vector. With `mode64`=1 the vector is 0xFFFF_FFFF_BFC0_0000. With `mode64`=0 it is 0x0000_0000_BFC0_0000. `mode64` is sampled at the edge that raises `vec_fetch_o`.
- R4: `status_we_o` is high exactly in the `vec_fetch_o` cycle. In that cycle `stat_erl_o`=1, `stat_bev_o`=1 and `stat_ts_o`=0.
- R5: `stat_sr_o` is 1 after a soft reset and 0 after a cold reset. A soft reset is an event during which the cold-reset input never went low.
- R6: If `cold_req_n` goes low at any point while an event is active, the event is cold. This holds even when the general reset started the event and the cold line was released before the general reset.
- R7: On a soft reset with `cisa_en`=0, `epc_we_o` pulses with `vec_fetch_o`. `epc_o` then equals `cur_pc` as sampled at the edge that raised `flush_o`, not the PC at release.
- R8: On a soft reset with `cisa_en`=1, `epc_o[63:1]` holds the captured PC bits and `epc_o[0]` holds `isa_mode`. Both are sampled at the same edge as R7, and `cisa_en` is sampled there too.
- R9: A cold reset does not raise `epc_we_o`, and `epc_o` keeps its previous value.
- R10: Between write-enable pulses, the status bits and `epc_o` hold their values regardless of `cur_pc`, `isa_mode`, `cisa_en` or `mode64`.
- R11: While `rst_n` is low, and right after it is released, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Block power-on reset, active low, asynchronous assert |
| reset_req_n | input | 1 | General reset request, active low, asynchronous |
| cold_req_n | input | 1 | Cold reset request, active low, asynchronous |
| cur_pc | input | 64 | Current program counter |
| mode64 | input | 1 | 1 = 64-bit addressing, 0 = 32-bit |
| cisa_en | input | 1 | Compressed-ISA execution enabled |
| isa_mode | input | 1 | Current ISA mode |
| flush_o | output | 1 | One-cycle state-machine flush at reset start |
| vec_fetch_o | output | 1 | One-cycle fetch redirect at reset release |
| vec_addr_o | output | 64 | Reset vector address |
| status_we_o | output | 1 | Status-bit write enable |
| stat_sr_o | output | 1 | Soft-reset indicator bit |
| stat_erl_o | output | 1 | Error-level bit |
| stat_bev_o | output | 1 | Bootstrap-vector bit |
| stat_ts_o | output | 1 | TLB-shutdown bit |
| epc_we_o | output | 1 | Error exception PC write enable |
| epc_o | output | 64 | Error exception PC value |

## Verification
The checker enforces, on every cycle, the following properties:
- Both pulses are one cycle wide.
- The status and error-PC write enables are tied to the vector fetch.
- ERL, BEV and TS take their fixed values.
- The SR bit and the error-PC write agree.
- The vector address matches the addressing mode seen the cycle before.
- The status bits and the error PC hold between writes.

Only the bench scenarios can show the properties that depend on event history:
- The synchroniser latency.
- The cold-over-soft priority when the cold line pulses in the middle of an event.
- Capture of the PC and ISA mode at assertion rather than at release.
- One flush and one fetch per event.

// File: rtl/rst_exc_pkg.sv
package rst_exc_pkg;

  // Low word of the reset vector; the upper word follows the addressing mode.
  localparam logic [31:0] VEC_LOW = 32'hBFC0_0000;

  typedef struct packed {
    logic sr;
    logic erl;
    logic bev;
    logic ts;
  } stat_t;

  typedef struct packed {
    logic rise;   // event starts this cycle
    logic fall;   // event released this cycle
    logic cold;   // event classified cold
  } evt_t;

endpackage

// File: rtl/rst_exc_sync.sv
module rst_exc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  output logic act
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], ~req_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign act = sh_q[STAGES-1];
endmodule

// File: rtl/rst_exc_track.sv
module rst_exc_track
  import rst_exc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic gen_act,
  input  logic cold_act,
  output evt_t evt
);
  logic any_act;
  logic act_q, act_d;
  logic cold_q, cold_d;

  always_comb begin
    any_act  = gen_act | cold_act;
    act_d    = any_act;
    evt.rise = any_act & ~act_q;
    evt.fall = ~any_act & act_q;
    // a new event restarts the cold record; otherwise it is sticky
    if (evt.rise) cold_d = cold_act;
    else          cold_d = cold_q | cold_act;
    evt.cold = cold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cold_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      cold_q <= cold_d;
    end
  end
endmodule

// File: rtl/rst_exc_out.sv
module rst_exc_out
  import rst_exc_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  evt_t              evt,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic              mode64,
  input  logic              cisa_en,
  input  logic              isa_mode,
  output logic              flush_o,
  output logic              vec_fetch_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              status_we_o,
  output stat_t             stat_o,
  output logic              epc_we_o,
  output logic [ADDR_W-1:0] epc_o
);
  localparam int HI_W = ADDR_W - 32;

  logic              flush_d;
  logic              vec_d;
  logic [ADDR_W-1:0] vaddr_q, vaddr_d;
  logic              swe_d;
  stat_t             stat_q, stat_d;
  logic              ewe_d;
  logic [ADDR_W-1:0] epc_q, epc_d;
  logic [ADDR_W-1:0] cap_q, cap_d;
  logic              cap_en, vec_en, epc_en;

  always_comb begin
    cap_en  = evt.rise;
    vec_en  = evt.fall;
    epc_en  = evt.fall & ~evt.cold;
    flush_d = evt.rise;
    vec_d   = vec_en;
    swe_d   = vec_en;
    ewe_d   = epc_en;

    cap_d = cap_q;
    if (cap_en) begin
      if (cisa_en) cap_d = {cur_pc[ADDR_W-1:1], isa_mode};
      else         cap_d = cur_pc;
    end

    vaddr_d = vaddr_q;
    stat_d  = stat_q;
    if (vec_en) begin
      vaddr_d    = {{HI_W{mode64}}, VEC_LOW};
      stat_d.sr  = ~evt.cold;
      stat_d.erl = 1'b1;
      stat_d.bev = 1'b1;
      stat_d.ts  = 1'b0;
    end

    epc_d = epc_en ? cap_q : epc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_o     <= 1'b0;
      vec_fetch_o <= 1'b0;
      status_we_o <= 1'b0;
      epc_we_o    <= 1'b0;
      vaddr_q     <= '0;
      stat_q      <= '0;
      epc_q       <= '0;
      cap_q       <= '0;
    end else begin
      flush_o     <= flush_d;
      vec_fetch_o <= vec_d;
      status_we_o <= swe_d;
      epc_we_o    <= ewe_d;
      vaddr_q     <= vaddr_d;
      stat_q      <= stat_d;
      epc_q       <= epc_d;
      cap_q       <= cap_d;
    end
  end

  assign vec_addr_o = vaddr_q;
  assign stat_o     = stat_q;
  assign epc_o      = epc_q;
endmodule

// File: rtl/rst_exc_seq.sv
module rst_exc_seq
  import rst_exc_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reset_req_n,
  input  logic              cold_req_n,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic              mode64,
  input  logic              cisa_en,
  input  logic              isa_mode,
  output logic              flush_o,
  output logic              vec_fetch_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              status_we_o,
  output logic              stat_sr_o,
  output logic              stat_erl_o,
  output logic              stat_bev_o,
  output logic              stat_ts_o,
  output logic              epc_we_o,
  output logic [ADDR_W-1:0] epc_o
);
  localparam int NREQ = 2;

  logic [NREQ-1:0] req_n;
  logic [NREQ-1:0] req_act;
  evt_t            evt;
  stat_t           stat;

  assign req_n = {cold_req_n, reset_req_n};

  for (genvar i = 0; i < NREQ; i++) begin : g_sync
    rst_exc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .req_n (req_n[i]),
      .act   (req_act[i])
    );
  end

  rst_exc_track u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .gen_act  (req_act[0]),
    .cold_act (req_act[1]),
    .evt      (evt)
  );

  rst_exc_out #(.ADDR_W(ADDR_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt         (evt),
    .cur_pc      (cur_pc),
    .mode64      (mode64),
    .cisa_en     (cisa_en),
    .isa_mode    (isa_mode),
    .flush_o     (flush_o),
    .vec_fetch_o (vec_fetch_o),
    .vec_addr_o  (vec_addr_o),
    .status_we_o (status_we_o),
    .stat_o      (stat),
    .epc_we_o    (epc_we_o),
    .epc_o       (epc_o)
  );

  assign stat_sr_o  = stat.sr;
  assign stat_erl_o = stat.erl;
  assign stat_bev_o = stat.bev;
  assign stat_ts_o  = stat.ts;
endmodule

// File: rtl/rst_exc_seq_chk.sv
module rst_exc_seq_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode64,
  input logic              flush_o,
  input logic              vec_fetch_o,
  input logic [ADDR_W-1:0] vec_addr_o,
  input logic              status_we_o,
  input logic              stat_sr_o,
  input logic              stat_erl_o,
  input logic              stat_bev_o,
  input logic              stat_ts_o,
  input logic              epc_we_o,
  input logic [ADDR_W-1:0] epc_o
);
  AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> !flush_o);  // R1
  AST_VEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch_o |=> !vec_fetch_o);  // R2
  AST_NO_FLUSH_AT_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    !(flush_o && vec_fetch_o));  // R2
  AST_VEC_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch_o |-> (vec_addr_o == {{(ADDR_W-32){$past(mode64)}}, 32'hBFC0_0000}));  // R3
  AST_STAT_WE: assert property (@(posedge clk) disable iff (!rst_n)
    status_we_o == vec_fetch_o);  // R4
  AST_STAT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch_o |-> (stat_erl_o && stat_bev_o && !stat_ts_o));  // R4
  AST_SR_EPC_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch_o |-> (epc_we_o == stat_sr_o));  // R5
  AST_EPC_WE_ONLY_AT_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    epc_we_o |-> vec_fetch_o);  // R9
  AST_EPC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !epc_we_o |-> $stable(epc_o));  // R10
  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !status_we_o |-> $stable({stat_sr_o, stat_erl_o, stat_bev_o, stat_ts_o}));  // R10
endmodule

bind rst_exc_seq rst_exc_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode64      (mode64),
  .flush_o     (flush_o),
  .vec_fetch_o (vec_fetch_o),
  .vec_addr_o  (vec_addr_o),
  .status_we_o (status_we_o),
  .stat_sr_o   (stat_sr_o),
  .stat_erl_o  (stat_erl_o),
  .stat_bev_o  (stat_bev_o),
  .stat_ts_o   (stat_ts_o),
  .epc_we_o    (epc_we_o),
  .epc_o       (epc_o)
);

// File: tb/rst_exc_seq_tb.sv
module rst_exc_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reset_req_n, cold_req_n;
  logic [63:0] cur_pc;
  logic        mode64, cisa_en, isa_mode;
  logic        flush_o, vec_fetch_o, status_we_o, epc_we_o;
  logic        stat_sr_o, stat_erl_o, stat_bev_o, stat_ts_o;
  logic [63:0] vec_addr_o, epc_o;

  int n_run  = 0;
  int n_fail = 0;
  int n_flush = 0;
  int n_vec   = 0;
  bit done   = 0;
  logic [63:0] exp_epc = '0;

  always #5 clk = ~clk;

  rst_exc_seq u_dut (
    .clk(clk), .rst_n(rst_n), .reset_req_n(reset_req_n), .cold_req_n(cold_req_n),
    .cur_pc(cur_pc), .mode64(mode64), .cisa_en(cisa_en), .isa_mode(isa_mode),
    .flush_o(flush_o), .vec_fetch_o(vec_fetch_o), .vec_addr_o(vec_addr_o),
    .status_we_o(status_we_o), .stat_sr_o(stat_sr_o), .stat_erl_o(stat_erl_o),
    .stat_bev_o(stat_bev_o), .stat_ts_o(stat_ts_o), .epc_we_o(epc_we_o), .epc_o(epc_o)
  );

  always @(negedge clk) begin
    if (rst_n && flush_o)     n_flush++;
    if (rst_n && vec_fetch_o) n_vec++;
  end

  typedef struct packed {
    logic        cold_start;
    logic        cold_mid;
    logic        m64;
    logic        ce;
    logic        isa;
    logic [63:0] pc;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 64'hFFFF_FFFF_8000_1234},
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 64'h0000_0000_8000_2000},
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 64'h1234_5678_8000_3003},
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 64'hAAAA_0000_0000_4444},
    '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 64'h0000_0000_9000_0010},
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 64'h0000_0000_8000_5555}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_event(input vec_t v, input bit gen_used);
    logic        is_cold;
    logic [63:0] cap;
    int          f0, v0;
    is_cold = v.cold_start | v.cold_mid;
    cap = v.ce ? {v.pc[63:1], v.isa} : v.pc;
    f0 = n_flush; v0 = n_vec;
    @(negedge clk);
    cur_pc = v.pc; mode64 = v.m64; cisa_en = v.ce; isa_mode = v.isa;
    reset_req_n = !gen_used;
    cold_req_n  = !v.cold_start;
    repeat (2) @(negedge clk);
    chk("R1 flush latency", {63'd0, flush_o}, 64'd0);
    @(negedge clk);
    chk("R1 flush pulse", {63'd0, flush_o}, 64'd1);
    @(negedge clk);
    chk("R1 flush width", {63'd0, flush_o}, 64'd0);
    // change state after capture: must not affect the saved PC (R7/R8/R10)
    cur_pc = ~v.pc; isa_mode = ~v.isa; cisa_en = ~v.ce;
    if (v.cold_mid) begin
      cold_req_n = 1'b0;
      repeat (3) @(negedge clk);
      cold_req_n = 1'b1;
    end
    repeat (4) @(negedge clk);
    chk("R1 one flush per event", 64'(n_flush - f0), 64'd1);
    reset_req_n = 1'b1; cold_req_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 vec latency", {63'd0, vec_fetch_o}, 64'd0);
    @(negedge clk);
    chk("R2 vec pulse", {63'd0, vec_fetch_o}, 64'd1);
    chk("R3 vector addr", vec_addr_o, v.m64 ? 64'hFFFF_FFFF_BFC0_0000 : 64'h0000_0000_BFC0_0000);
    chk("R4 status we", {63'd0, status_we_o}, 64'd1);
    chk("R4 erl/bev/ts", {61'd0, stat_erl_o, stat_bev_o, stat_ts_o}, 64'b110);
    chk("R5 R6 sr", {63'd0, stat_sr_o}, {63'd0, !is_cold});
    chk("R9 epc we", {63'd0, epc_we_o}, {63'd0, !is_cold});
    if (!is_cold) exp_epc = cap;
    chk(v.ce ? "R8 epc isa" : "R7 epc pc", epc_o, exp_epc);
    @(negedge clk);
    chk("R2 vec width", {63'd0, vec_fetch_o}, 64'd0);
    chk("R10 epc hold", epc_o, exp_epc);
    chk("R10 sr hold", {63'd0, stat_sr_o}, {63'd0, !is_cold});
    chk("R2 one vec per release", 64'(n_vec - v0), 64'd1);
  endtask

  initial begin
    rst_n = 1'b0; reset_req_n = 1'b1; cold_req_n = 1'b1;
    cur_pc = '0; mode64 = 1'b0; cisa_en = 1'b0; isa_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset outputs", {flush_o, vec_fetch_o, status_we_o, epc_we_o,
         stat_sr_o, stat_erl_o, stat_bev_o, stat_ts_o}, 64'd0);
    chk("R11 reset vec/epc", vec_addr_o | epc_o, 64'd0);

    for (int i = 0; i < 6; i++) run_event(VECS[i], 1'b1);

    // cold line alone, general reset never asserted (R6 / R9)
    run_event('{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 64'h0000_0000_DEAD_BEE0}, 1'b0);
    // soft again after a cold: SR returns to 1 (R5)
    run_event('{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 64'h0000_0000_0000_0100}, 1'b1);

    // inputs wiggle outside any event: nothing changes (R10)
    repeat (3) begin
      @(negedge clk);
      cur_pc = cur_pc + 64'h40; isa_mode = ~isa_mode; cisa_en = ~cisa_en; mode64 = ~mode64;
    end
    @(negedge clk);
    chk("R10 idle epc", epc_o, exp_epc);
    chk("R10 idle pulses", {62'd0, flush_o, vec_fetch_o}, 64'd0);

    // block reset clears everything (R11)
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R11 mid-run reset", {stat_sr_o, stat_erl_o, stat_bev_o, 61'd0} | epc_o, 64'd0);
    rst_n = 1'b1;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule